// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small memory-mapped bank of control and status registers for a chip's system-control area. Software reaches it through a plain register bus: an address, a write strobe with write data, and a read strobe with combinational read data. The bank drives a set of per-device enable outputs, a field of write-once configuration bits and a peripheral reset line. It also shows a fixed silicon revision number.

The configuration registers refuse writes until software opens the bank. To do so it writes a first key to one kick register and then a second key to a second kick register. The device-control register needs one more guard on top of that: a separate lock register must hold its own key value. A write that any guard refuses has no effect and raises a sticky error output. Reads are never refused.

Device 12 has a field that cannot be disabled. Once it is enabled it stays enabled until reset.

Top module: `keybank_top`

## Requirements
- R1: After reset the bank is locked, every device field is 0 and `devEnable` is all zero, the write-once field is 0 and marked unwritten, `rmiiReset` is 0 and `errFlag` is 0.
- R2: Writing 0x83E70B13 to the first kick register (0x10) and then 0x95A4F1E0 to the second kick register (0x14) opens the bank. Bit 0 of a read at 0x10 is 1 exactly while the bank is open, and the other bits read 0.
- R3: The bank returns to locked in any of these cases: a wrong value is written to either kick register (including while the bank is open), the second key is written while no first key is pending, or any other address is written while the first key is pending.
- R4: While the bank is locked, writes to 0x20, 0x24, 0x28 and 0x2C are dropped and set `errFlag`. `errFlag` stays set until reset. Reads return register contents whether the bank is locked or open.
- R5: A write to the device-control register (0x24) takes effect only when the bank is open and the lock register (0x20, readable) holds 0x0F0A0B00. Otherwise the write is dropped and `errFlag` is set.
- R6: Devices 0 to 11 each own the 2-bit field at bits [2i+1:2i] of 0x24. A write stores the value, and `devEnable[i]` is 1 exactly when the field holds 1. Writing 0 disables the device.
- R7: Device 12 owns bits [31:30] of 0x24, and its enable value is 3. A write carrying 3 there enables it. Any other value leaves the field unchanged, so the device can never be disabled. `devEnable[12]` shows the field equals 3, and bits [29:24] read 0.
- R8: The first write to 0x28 that the bank accepts loads bits [7:0] into `onceCfg` and sets read bit 31. Later writes to 0x28 leave the register unchanged until reset.
- R9: Address 0x08 reads the 4-bit revision in bits [31:28] (default 3) with zeros elsewhere. Writes to it have no effect.
- R10: Bit 18 of the register at 0x2C drives `rmiiReset`. The other bits of 0x2C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe; rdata is zero when low |
| rdata | output | 32 | Combinational read data |
| devEnable | output | 13 | Per-device enable, bit i for device i |
| onceCfg | output | 8 | Write-once configuration bits |
| rmiiReset | output | 1 | Peripheral reset line |
| errFlag | output | 1 | Sticky flag for refused writes |

## Verification
The bench targets sequences that only look like an unlock:
- the second key written first;
- the first key followed by a write elsewhere;
- a wrong second key;
- a stray value written to a kick register while the bank is open.

A design that keeps the first key pending in any of these cases would open the bank when it should stay locked.

The bench also clears the low device fields and checks that device 12 stays enabled; a design that treats that field like the others would drop its enable. It writes the write-once register twice and checks that the second value is ignored. It writes the device register with the lock key missing and checks that the write is refused; a design that only tracks the kick state would let that write through.

// File: rtl/keybank_pkg.sv
`timescale 1ns/1ps
package keybank_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } kickState_t;

  typedef struct packed {
    logic wrLock;
    logic wrDev;
    logic wrOnce;
    logic wrRst;
    logic blocked;
  } bankStrobe_t;

endpackage

// File: rtl/keybank_ctrl.sv
`timescale 1ns/1ps
module keybank_ctrl
  import keybank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK_A_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] KICK_B_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 8'h20,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h24,
  parameter logic [ADDR_W-1:0] ONCE_ADDR   = 8'h28,
  parameter logic [ADDR_W-1:0] RST_ADDR    = 8'h2C,
  parameter logic [DATA_W-1:0] KEY_A       = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B       = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              lockOk,
  output bankStrobe_t       strb,
  output logic              unlocked,
  output logic              errFlag
);

  kickState_t state, stateNext;
  logic hitKickA, hitKickB, hitLock, hitDev, hitOnce, hitRst, hitProt, open;

  assign hitKickA = (addr == KICK_A_ADDR);
  assign hitKickB = (addr == KICK_B_ADDR);
  assign hitLock  = (addr == LOCK_ADDR);
  assign hitDev   = (addr == DEV_ADDR);
  assign hitOnce  = (addr == ONCE_ADDR);
  assign hitRst   = (addr == RST_ADDR);
  assign hitProt  = hitLock | hitDev | hitOnce | hitRst;

  // Kick handshake: first key arms, second key opens, anything else relocks
  always_comb begin
    stateNext = state;
    if (wr) begin
      if (hitKickA)
        stateNext = (wdata == KEY_A) ? KS_HALF : KS_LOCKED;
      else if (hitKickB)
        stateNext = (wdata == KEY_B && state != KS_LOCKED) ? KS_OPEN : KS_LOCKED;
      else if (state == KS_HALF)
        stateNext = KS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= KS_LOCKED;
    else       state <= stateNext;
  end

  assign unlocked = (state == KS_OPEN);
  assign open     = wr & unlocked;

  always_comb begin
    strb.wrLock  = open & hitLock;
    strb.wrDev   = open & hitDev & lockOk;
    strb.wrOnce  = open & hitOnce;
    strb.wrRst   = open & hitRst;
    strb.blocked = wr & hitProt & (~unlocked | (hitDev & ~lockOk));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (strb.blocked) errFlag <= 1'b1;
  end

endmodule

// File: rtl/keybank_datapath.sv
`timescale 1ns/1ps
module keybank_datapath
  import keybank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_LOW_DEV = 12,
  parameter int FIELD_W     = 2,
  parameter int ONCE_W      = 8,
  parameter int REV_W       = 4,
  parameter logic [REV_W-1:0] REV_VALUE = 4'h3,
  parameter int RST_BIT     = 18,
  parameter logic [ADDR_W-1:0] REV_ADDR    = 8'h08,
  parameter logic [ADDR_W-1:0] KICK_A_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 8'h20,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h24,
  parameter logic [ADDR_W-1:0] ONCE_ADDR   = 8'h28,
  parameter logic [ADDR_W-1:0] RST_ADDR    = 8'h2C,
  parameter logic [DATA_W-1:0] LOCK_KEY    = 32'h0F0A0B00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   rd,
  input  bankStrobe_t            strb,
  input  logic                   unlocked,
  output logic                   lockOk,
  output logic [DATA_W-1:0]      rdata,
  output logic [NUM_LOW_DEV:0]   devEnable,
  output logic [ONCE_W-1:0]      onceCfg,
  output logic                   rmiiReset
);

  localparam int LOW_SPAN = NUM_LOW_DEV * FIELD_W;
  localparam int GAP_W    = DATA_W - FIELD_W - LOW_SPAN;
  localparam logic [FIELD_W-1:0] LOW_EN_VAL = FIELD_W'(1);
  localparam logic [FIELD_W-1:0] TOP_EN_VAL = '1;

  logic [DATA_W-1:0]   lockReg;
  logic [LOW_SPAN-1:0] devLow;
  logic [FIELD_W-1:0]  devTop;
  logic [ONCE_W-1:0]   onceReg;
  logic                onceDone;
  logic                rstBit;
  logic [DATA_W-1:0]   readMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockReg  <= '0;
      devLow   <= '0;
      devTop   <= '0;
      onceReg  <= '0;
      onceDone <= 1'b0;
      rstBit   <= 1'b0;
    end else begin
      if (strb.wrLock) lockReg <= wdata;
      if (strb.wrDev) begin
        devLow <= wdata[LOW_SPAN-1:0];
        if (wdata[DATA_W-1 -: FIELD_W] == TOP_EN_VAL) devTop <= TOP_EN_VAL;
      end
      if (strb.wrOnce && !onceDone) begin
        onceReg  <= wdata[ONCE_W-1:0];
        onceDone <= 1'b1;
      end
      if (strb.wrRst) rstBit <= wdata[RST_BIT];
    end
  end

  assign lockOk = (lockReg == LOCK_KEY);

  for (genvar i = 0; i < NUM_LOW_DEV; i++) begin : g_lowEn
    assign devEnable[i] = (devLow[i*FIELD_W +: FIELD_W] == LOW_EN_VAL);
  end
  assign devEnable[NUM_LOW_DEV] = (devTop == TOP_EN_VAL);

  assign onceCfg   = onceReg;
  assign rmiiReset = rstBit;

  always_comb begin
    readMux = '0;
    case (addr)
      REV_ADDR:    readMux = {REV_VALUE, {(DATA_W-REV_W){1'b0}}};
      KICK_A_ADDR: readMux = DATA_W'(unlocked);
      LOCK_ADDR:   readMux = lockReg;
      DEV_ADDR:    readMux = {devTop, {GAP_W{1'b0}}, devLow};
      ONCE_ADDR:   readMux = {onceDone, {(DATA_W-1-ONCE_W){1'b0}}, onceReg};
      RST_ADDR:    readMux = DATA_W'(rstBit) << RST_BIT;
      default:     readMux = '0;
    endcase
  end

  assign rdata = rd ? readMux : '0;

endmodule

// File: rtl/keybank_top.sv
`timescale 1ns/1ps
module keybank_top
  import keybank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_LOW_DEV = 12,
  parameter int FIELD_W     = 2,
  parameter int ONCE_W      = 8,
  parameter int REV_W       = 4,
  parameter logic [REV_W-1:0] REV_VALUE = 4'h3,
  parameter int RST_BIT     = 18,
  parameter logic [ADDR_W-1:0] REV_ADDR    = 8'h08,
  parameter logic [ADDR_W-1:0] KICK_A_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] KICK_B_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 8'h20,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h24,
  parameter logic [ADDR_W-1:0] ONCE_ADDR   = 8'h28,
  parameter logic [ADDR_W-1:0] RST_ADDR    = 8'h2C,
  parameter logic [DATA_W-1:0] KEY_A       = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B       = 32'h95A4F1E0,
  parameter logic [DATA_W-1:0] LOCK_KEY    = 32'h0F0A0B00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr,
  input  logic                 rd,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LOW_DEV:0] devEnable,
  output logic [ONCE_W-1:0]    onceCfg,
  output logic                 rmiiReset,
  output logic                 errFlag
);

  bankStrobe_t strb;
  logic        unlocked;
  logic        lockOk;

  keybank_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KICK_A_ADDR(KICK_A_ADDR), .KICK_B_ADDR(KICK_B_ADDR),
    .LOCK_ADDR(LOCK_ADDR), .DEV_ADDR(DEV_ADDR),
    .ONCE_ADDR(ONCE_ADDR), .RST_ADDR(RST_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .wr(wr),
    .lockOk(lockOk), .strb(strb), .unlocked(unlocked), .errFlag(errFlag)
  );

  keybank_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOW_DEV(NUM_LOW_DEV),
    .FIELD_W(FIELD_W), .ONCE_W(ONCE_W), .REV_W(REV_W), .REV_VALUE(REV_VALUE),
    .RST_BIT(RST_BIT), .REV_ADDR(REV_ADDR), .KICK_A_ADDR(KICK_A_ADDR),
    .LOCK_ADDR(LOCK_ADDR), .DEV_ADDR(DEV_ADDR), .ONCE_ADDR(ONCE_ADDR),
    .RST_ADDR(RST_ADDR), .LOCK_KEY(LOCK_KEY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .rd(rd),
    .strb(strb), .unlocked(unlocked), .lockOk(lockOk), .rdata(rdata),
    .devEnable(devEnable), .onceCfg(onceCfg), .rmiiReset(rmiiReset)
  );

endmodule

// File: rtl/keybank_checker.sv
`timescale 1ns/1ps
module keybank_checker
  import keybank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_LOW_DEV = 12,
  parameter int ONCE_W      = 8,
  parameter logic [ADDR_W-1:0] ONCE_ADDR = 8'h28,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 8'h2C
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wr,
  input logic                 unlocked,
  input bankStrobe_t          strb,
  input logic [NUM_LOW_DEV:0] devEnable,
  input logic [ONCE_W-1:0]    onceCfg,
  input logic                 rmiiReset,
  input logic                 errFlag
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) errFlag |=> errFlag); // R4
  AST_BLOCK_SETS_ERR: assert property (@(posedge clk) disable iff (!rstN) strb.blocked |=> errFlag); // R4
  AST_LOCKED_DEV_HOLD: assert property (@(posedge clk) disable iff (!rstN) (wr && !unlocked) |=> $stable(devEnable)); // R4
  AST_TOP_DEV_NO_DISABLE: assert property (@(posedge clk) disable iff (!rstN) devEnable[NUM_LOW_DEV] |=> devEnable[NUM_LOW_DEV]); // R7
  AST_ONCE_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN) (wr && addr == ONCE_ADDR && !unlocked) |=> $stable(onceCfg)); // R8
  AST_RST_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN) !(wr && addr == RST_ADDR) |=> $stable(rmiiReset)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strb.wrLock, strb.wrDev, strb.wrOnce, strb.wrRst})); // R5

endmodule

bind keybank_top keybank_checker #(
  .ADDR_W(ADDR_W), .NUM_LOW_DEV(NUM_LOW_DEV), .ONCE_W(ONCE_W),
  .ONCE_ADDR(ONCE_ADDR), .RST_ADDR(RST_ADDR)
) u_keybank_checker (
  .clk(clk), .rstN(rstN), .addr(addr), .wr(wr), .unlocked(unlocked),
  .strb(strb), .devEnable(devEnable), .onceCfg(onceCfg),
  .rmiiReset(rmiiReset), .errFlag(errFlag)
);

// File: tb/test_keybank_top.sv
`timescale 1ns/1ps
module test_keybank_top;

  localparam logic [31:0] KA = 32'h83E70B13;
  localparam logic [31:0] KB = 32'h95A4F1E0;
  localparam logic [31:0] LK = 32'h0F0A0B00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [12:0] devEnable;
  logic [7:0]  onceCfg;
  logic        rmiiReset;
  logic        errFlag;

  int checks = 0;
  int fails = 0;

  keybank_top i_keybank_top (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .devEnable(devEnable), .onceCfg(onceCfg),
    .rmiiReset(rmiiReset), .errFlag(errFlag)
  );

  always #4 clk = ~clk;

  // Behavioural reference model
  int          mKick;   // 0 locked, 1 first key seen, 2 open
  logic [31:0] mLock;
  logic [1:0]  mField [13];
  logic [7:0]  mOnce;
  bit          mOnceDone;
  bit          mRst;
  bit          mErr;
  bit          wasOpen;

  task automatic modelReset();
    mKick = 0; mLock = 0; mOnce = 0; mOnceDone = 0; mRst = 0; mErr = 0;
    for (int i = 0; i < 13; i++) mField[i] = 2'd0;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else if (wr) begin
      wasOpen = (mKick == 2);
      if (addr == 8'h10) mKick = (wdata == KA) ? 1 : 0;
      else if (addr == 8'h14) mKick = (wdata == KB && mKick != 0) ? 2 : 0;
      else if (mKick == 1) mKick = 0;
      if (addr inside {8'h20, 8'h24, 8'h28, 8'h2C}) begin
        if (!wasOpen) mErr = 1;
        else if (addr == 8'h20) mLock = wdata;
        else if (addr == 8'h24) begin
          if (mLock != LK) mErr = 1;
          else begin
            for (int i = 0; i < 12; i++) mField[i] = wdata[2*i +: 2];
            if (wdata[31:30] == 2'd3) mField[12] = 2'd3;
          end
        end
        else if (addr == 8'h28) begin
          if (!mOnceDone) begin mOnce = wdata[7:0]; mOnceDone = 1; end
        end
        else mRst = wdata[18];
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [7:0] a);
    logic [31:0] v;
    v = 0;
    case (a)
      8'h08: v = 32'h3000_0000;
      8'h10: v = (mKick == 2) ? 32'd1 : 32'd0;
      8'h20: v = mLock;
      8'h24: begin
        for (int i = 0; i < 12; i++) v[2*i +: 2] = mField[i];
        v[31:30] = mField[12];
      end
      8'h28: v = {mOnceDone, 23'd0, mOnce};
      8'h2C: v = {13'd0, mRst, 18'd0};
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic logic [12:0] modelEn();
    logic [12:0] e;
    for (int i = 0; i < 12; i++) e[i] = (mField[i] == 2'd1);
    e[12] = (mField[12] == 2'd3);
    return e;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R6 devEnable vs model", 32'(devEnable), 32'(modelEn()));
      check("R8 onceCfg vs model", 32'(onceCfg), 32'(mOnce));
      check("R10 rmiiReset vs model", 32'(rmiiReset), 32'(mRst));
      check("R4 errFlag vs model", 32'(errFlag), 32'(mErr));
      check("R2 rdata vs model", rdata, rd ? modelRead(addr) : 32'd0);
    end
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic readChk(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    addr = a; rd = 1'b1;
    @(negedge clk);
    check(tag, rdata, exp);
    #1 rd = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check("R1 devEnable after reset", 32'(devEnable), 32'd0);
    check("R1 onceCfg after reset", 32'(onceCfg), 32'd0);
    check("R1 errFlag after reset", 32'(errFlag), 32'd0);
    check("R1 rmiiReset after reset", 32'(rmiiReset), 32'd0);
    readChk(8'h10, 32'd0, "R1 bank locked");
    readChk(8'h28, 32'd0, "R1 once unwritten");

    readChk(8'h08, 32'h3000_0000, "R9 revision");
    busWrite(8'h08, 32'hFFFF_FFFF);
    readChk(8'h08, 32'h3000_0000, "R9 revision after write");
    check("R9 no error on revision write", 32'(errFlag), 32'd0);

    busWrite(8'h24, 32'h0000_0001);
    check("R4 blocked write sets error", 32'(errFlag), 32'd1);
    check("R4 blocked dev write", 32'(devEnable), 32'd0);
    readChk(8'h24, 32'd0, "R4 read while locked");

    busWrite(8'h14, KB);
    readChk(8'h10, 32'd0, "R3 second key first");
    busWrite(8'h10, KA);
    busWrite(8'h08, 32'd0);
    busWrite(8'h14, KB);
    readChk(8'h10, 32'd0, "R3 other write between keys");
    busWrite(8'h10, KA);
    busWrite(8'h14, 32'h1234_5678);
    readChk(8'h10, 32'd0, "R3 wrong second key");

    busWrite(8'h10, KA);
    busWrite(8'h14, KB);
    readChk(8'h10, 32'd1, "R2 bank open");

    busWrite(8'h24, 32'h0000_0001);
    readChk(8'h24, 32'd0, "R5 dev write without lock key");
    busWrite(8'h20, LK);
    readChk(8'h20, LK, "R5 lock register");
    busWrite(8'h24, 32'hFF00_0955);
    readChk(8'h24, 32'hC000_0955, "R7 dev fields and gap");
    check("R6 low device enables", 32'(devEnable), 32'h0000_101F);
    busWrite(8'h24, 32'h0000_0000);
    readChk(8'h24, 32'hC000_0000, "R7 field kept");
    check("R7 device 12 stays enabled", 32'(devEnable), 32'h0000_1000);
    busWrite(8'h24, 32'h0000_0004);
    check("R6 device 1 enabled", 32'(devEnable), 32'h0000_1002);

    busWrite(8'h28, 32'h0000_00A5);
    readChk(8'h28, 32'h8000_00A5, "R8 first once write");
    busWrite(8'h28, 32'h0000_003C);
    check("R8 second once write ignored", 32'(onceCfg), 32'h0000_00A5);

    busWrite(8'h2C, 32'hFFFF_FFFF);
    check("R10 reset line set", 32'(rmiiReset), 32'd1);
    readChk(8'h2C, 32'h0004_0000, "R10 reset register");
    busWrite(8'h2C, 32'h0000_0000);
    check("R10 reset line cleared", 32'(rmiiReset), 32'd0);

    busWrite(8'h14, 32'h0000_0001);
    readChk(8'h10, 32'd0, "R3 stray kick value relocks");
    busWrite(8'h2C, 32'h0004_0000);
    check("R4 reset line held while locked", 32'(rmiiReset), 32'd0);

    busWrite(8'h10, KA);
    busWrite(8'h14, KB);
    busWrite(8'h20, 32'h0000_0000);
    busWrite(8'h24, 32'h0000_0001);
    check("R5 dev write after lock cleared", 32'(devEnable), 32'h0000_1002);

    @(posedge clk); #2 rstN = 1'b0;
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    check("R1 devEnable after second reset", 32'(devEnable), 32'd0);
    check("R1 errFlag after second reset", 32'(errFlag), 32'd0);
    readChk(8'h28, 32'd0, "R1 once cleared");

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule